// File: doc/BRIEF.md
# Control-Register Port Write Sequencer

This block performs single writes into the internal control-register space of a PHY through a narrow handshake port. A requester presents a 16-bit address and a 16-bit data word with a valid/ready pair. The sequencer then runs three sub-transactions in a fixed order: capture address, capture data, commit write. Each sub-transaction is a complete four-phase handshake. The block drives the data-in bus with one strobe. It waits for the PHY acknowledge to rise, drops the strobe while leaving the bus unchanged, and then waits for the acknowledge to fall.

The acknowledge input is resynchronised through a two-flop synchroniser, because the PHY may run from a different clock. Every wait for an acknowledge edge is bounded by a number of poll intervals. A parameterised prescaler sets the length of one interval, so the bound is a fixed time and does not depend on the core clock rate. If either edge fails to arrive within the bound, the write is abandoned, all strobes go low, and a one-cycle error pulse reports which edge timed out. A completed write gives a one-cycle done pulse.

Top module: `crp_write_master`

## Requirements
- R1: After reset, and whenever no write is in progress, `req_ready` is high, all three strobes are low, and `done_pulse` and `err_pulse` are low.
- R2: A request is accepted only when `req_ready` is high. While a write is in progress, `req_valid` and the request fields are ignored, and the write in progress keeps its original address and data.
- R3: A write raises the strobes one at a time, never more than one at once, in the order `cr_cap_addr`, then `cr_cap_data`, then `cr_write`.
- R4: `cr_din` holds the request address while `cr_cap_addr` is high, and the request data word while `cr_cap_data` or `cr_write` is high.
- R5: A strobe stays high until the synchronised acknowledge is seen high. It then falls, and `cr_din` keeps its value on the cycle the strobe falls.
- R6: After a strobe falls, the next strobe is not raised until the acknowledge has returned low.
- R7: After the acknowledge falls in the commit phase, `done_pulse` is high for exactly one cycle with `err_code` = 0, and the block returns to idle.
- R8: If the acknowledge does not rise within the bound, the write aborts. `err_pulse` is high for one cycle with `err_code` = 1, all strobes go low, and the block returns to idle.
- R9: If the acknowledge does not fall within the bound, the write aborts. `err_pulse` is high for one cycle with `err_code` = 2, and the block returns to idle.
- R10: Each wait lasts exactly TIMEOUT_TICKS × TICK_DIV core cycles before it times out. The count restarts at the start of every wait, so an acknowledge that arrives earlier than that completes the phase normally.
- R11: The acknowledge passes through a two-flop synchroniser. A strobe falls on the third rising clock edge after the acknowledge rises.
- R12: `err_code` is 0 whenever `err_pulse` is low, and `done_pulse` and `err_pulse` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Sequencer idle, request accepted this cycle if valid |
| req_addr | input | 16 | Control-register address |
| req_data | input | 16 | Control-register data word |
| cr_din | output | 16 | Data-in bus to the PHY port |
| cr_cap_addr | output | 1 | Address capture strobe |
| cr_cap_data | output | 1 | Data capture strobe |
| cr_write | output | 1 | Commit write strobe |
| cr_ack | input | 1 | Acknowledge from the PHY, asynchronous |
| done_pulse | output | 1 | One-cycle pulse on successful write |
| err_pulse | output | 1 | One-cycle pulse on aborted write |
| err_code | output | 2 | Cause with err_pulse: 1 rise timeout, 2 fall timeout |

## Verification
The hardest situations to reach are the two timeouts, and above all the fall timeout. To reach it the PHY must acknowledge a strobe and then hold its acknowledge high for the whole bound, in one chosen phase. The bench's responder model can be set to stall either edge in any of the three phases. It counts the exact number of cycles spent waiting, which pins the bound to the cycle. A random mix of acknowledge delays also brings out the case where a request arrives while the sequencer is busy.

// File: rtl/crp_pkg.sv
// Package: shared types for the control-register port write sequencer.
// Assumes: 2-bit encodings are observed directly at the block's ports.
package crp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RISE = 2'd1,
        ST_FALL = 2'd2
    } crp_state_t;

    typedef enum logic [1:0] {
        PH_ADDR   = 2'd0,
        PH_DATA   = 2'd1,
        PH_COMMIT = 2'd2
    } crp_phase_t;

    typedef enum logic [1:0] {
        CRP_OK      = 2'd0,
        CRP_RISE_TO = 2'd1,
        CRP_FALL_TO = 2'd2
    } crp_err_t;
endpackage

// File: rtl/crp_sync.sv
// Module: multi-flop synchroniser for a single asynchronous level.
// Assumes: the input is a slow level (a handshake), not a pulse.
module crp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d_async};
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/crp_tick.sv
// Module: poll-interval prescaler; emits one tick every DIV core cycles.
// Assumes: clr restarts the interval so the first tick comes DIV cycles
// after the clearing edge.
module crp_tick #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_pass
            assign tick = 1'b1;
        end else begin : g_div
            localparam int CW = $clog2(DIV);
            logic [CW-1:0] cnt;

            assign tick = (cnt == CW'(DIV - 1));

            // Count core cycles within the current poll interval.
            always_ff @(posedge clk) begin
                if (!rst_n || clr) cnt <= '0;
                else if (tick)     cnt <= '0;
                else               cnt <= cnt + 1'b1;
            end
        end
    endgenerate
endmodule

// File: rtl/crp_seq.sv
// Module: three-phase write sequencer with per-edge acknowledge timeouts.
// Assumes: ack_s is already synchronised; tick is one poll interval.
module crp_seq
    import crp_pkg::*;
#(
    parameter int WORD_W        = 16,
    parameter int TIMEOUT_TICKS = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [WORD_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_data,
    output logic              req_ready,
    input  logic              ack_s,
    input  logic              tick,
    output logic              restart,
    output logic [WORD_W-1:0] din,
    output logic              stb_addr,
    output logic              stb_data,
    output logic              stb_write,
    output logic              done_pulse,
    output logic              err_pulse,
    output logic [1:0]        err_code
);
    localparam int TW = $clog2(TIMEOUT_TICKS + 1);

    crp_state_t        state;
    crp_phase_t        phase;
    logic [WORD_W-1:0] addr_q, data_q;
    logic [TW-1:0]     tcnt;
    logic              accept, rise_ok, fall_ok, expire;

    assign req_ready = (state == ST_IDLE);
    assign accept    = req_ready && req_valid;
    assign rise_ok   = (state == ST_RISE) && ack_s;
    assign fall_ok   = (state == ST_FALL) && !ack_s;
    assign expire    = (state != ST_IDLE) && !rise_ok && !fall_ok && tick
                       && (tcnt == TW'(TIMEOUT_TICKS - 1));
    assign restart   = accept || rise_ok || fall_ok;

    // Bus value: the address in the first phase, the data word afterwards.
    assign din       = (phase == PH_ADDR) ? addr_q : data_q;
    assign stb_addr  = (state == ST_RISE) && (phase == PH_ADDR);
    assign stb_data  = (state == ST_RISE) && (phase == PH_DATA);
    assign stb_write = (state == ST_RISE) && (phase == PH_COMMIT);

    // Capture the request fields at acceptance only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (accept) begin
            addr_q <= req_addr;
            data_q <= req_data;
        end
    end

    // Count poll intervals spent in the current acknowledge wait.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) tcnt <= '0;
        else if (tick && state != ST_IDLE) tcnt <= tcnt + 1'b1;
    end

    // Main handshake state machine and result pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            phase      <= PH_ADDR;
            done_pulse <= 1'b0;
            err_pulse  <= 1'b0;
            err_code   <= CRP_OK;
        end else begin
            done_pulse <= 1'b0;
            err_pulse  <= 1'b0;
            err_code   <= CRP_OK;
            unique case (state)
                ST_IDLE: if (accept) begin
                    state <= ST_RISE;
                    phase <= PH_ADDR;
                end
                ST_RISE: if (rise_ok) begin
                    state <= ST_FALL;
                end else if (expire) begin
                    state     <= ST_IDLE;
                    err_pulse <= 1'b1;
                    err_code  <= CRP_RISE_TO;
                end
                ST_FALL: if (fall_ok) begin
                    if (phase == PH_COMMIT) begin
                        state      <= ST_IDLE;
                        done_pulse <= 1'b1;
                    end else begin
                        state <= ST_RISE;
                        phase <= (phase == PH_ADDR) ? PH_DATA : PH_COMMIT;
                    end
                end else if (expire) begin
                    state     <= ST_IDLE;
                    err_pulse <= 1'b1;
                    err_code  <= CRP_FALL_TO;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/crp_write_master.sv
// Module: top of the control-register port write sequencer.
// Assumes: cr_ack is asynchronous to clk; one write is in flight at most.
module crp_write_master #(
    parameter int WORD_W        = 16,
    parameter int SYNC_STAGES   = 2,
    parameter int TICK_DIV      = 8,
    parameter int TIMEOUT_TICKS = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [WORD_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_data,
    output logic [WORD_W-1:0] cr_din,
    output logic              cr_cap_addr,
    output logic              cr_cap_data,
    output logic              cr_write,
    input  logic              cr_ack,
    output logic              done_pulse,
    output logic              err_pulse,
    output logic [1:0]        err_code
);
    logic ack_s, tick, restart;

    crp_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .d_async(cr_ack), .q_sync(ack_s)
    );

    crp_tick #(.DIV(TICK_DIV)) tick_i (
        .clk(clk), .rst_n(rst_n), .clr(restart), .tick(tick)
    );

    crp_seq #(.WORD_W(WORD_W), .TIMEOUT_TICKS(TIMEOUT_TICKS)) seq_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr), .req_data(req_data),
        .req_ready(req_ready), .ack_s(ack_s), .tick(tick), .restart(restart),
        .din(cr_din), .stb_addr(cr_cap_addr), .stb_data(cr_cap_data),
        .stb_write(cr_write), .done_pulse(done_pulse), .err_pulse(err_pulse),
        .err_code(err_code)
    );
endmodule

// File: rtl/crp_write_master_chk.sv
// Module: port-level protocol checks for crp_write_master, bound below.
// Assumes: synchronous active-low reset on rst_n.
module crp_write_master_chk #(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic [WORD_W-1:0] cr_din,
    input logic              cr_cap_addr,
    input logic              cr_cap_data,
    input logic              cr_write,
    input logic              done_pulse,
    input logic              err_pulse,
    input logic [1:0]        err_code
);
    logic any_stb;
    assign any_stb = cr_cap_addr | cr_cap_data | cr_write;

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !any_stb);

    // R3
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cr_write, cr_cap_data, cr_cap_addr}));

    // R4
    din_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (any_stb && $past(any_stb)) |-> $stable(cr_din));

    // R5
    din_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(any_stb) |-> $stable(cr_din));

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse);

    // R8
    err_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> (err_code != 2'd0));

    // R12
    code_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !err_pulse |-> (err_code == 2'd0));

    // R12
    result_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_pulse && err_pulse));
endmodule

bind crp_write_master crp_write_master_chk #(.WORD_W(WORD_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .cr_din(cr_din),
    .cr_cap_addr(cr_cap_addr), .cr_cap_data(cr_cap_data), .cr_write(cr_write),
    .done_pulse(done_pulse), .err_pulse(err_pulse), .err_code(err_code)
);

// File: tb/crp_write_master_tb_top.sv
// Bench: random and directed writes against a PHY responder model.
module crp_write_master_tb_top;
    localparam int W   = 16;
    localparam int DIV = 8;
    localparam int TO  = 100;
    localparam int BOUND = DIV * TO;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [W-1:0]  req_addr = '0, req_data = '0;
    logic          req_ready;
    logic [W-1:0]  cr_din;
    logic          cr_cap_addr, cr_cap_data, cr_write;
    logic          cr_ack = 1'b0;
    logic          done_pulse, err_pulse;
    logic [1:0]    err_code;

    int checks = 0, errors = 0, cycles = 0;
    bit finished = 0;

    // Responder configuration and observations.
    int        rise_d = 2, fall_d = 2;
    int        stall_rise_ph = -1, stall_fall_ph = -1;
    int        n_seen = 0;
    logic [2:0]   seen_kind [0:3];
    logic [W-1:0] seen_din  [0:3];
    bit        hold_ok = 1, lat_ok = 1, order_ok = 1, stb_ok = 1;
    int        hi_cnt = 0, lo_cnt = 0;

    always #2.5 clk = ~clk;

    crp_write_master #(.WORD_W(W), .TICK_DIV(DIV), .TIMEOUT_TICKS(TO)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_data(req_data), .cr_din(cr_din),
        .cr_cap_addr(cr_cap_addr), .cr_cap_data(cr_cap_data), .cr_write(cr_write),
        .cr_ack(cr_ack), .done_pulse(done_pulse), .err_pulse(err_pulse),
        .err_code(err_code)
    );

    function automatic bit any_stb();
        return cr_cap_addr | cr_cap_data | cr_write;
    endfunction

    function automatic int exp_code(int sr, int sf);
        if (sr >= 0) return 1;
        if (sf >= 0) return 2;
        return 0;
    endfunction

    function automatic int exp_phases(int sr, int sf);
        if (sr >= 0) return sr + 1;
        if (sf >= 0) return sf + 1;
        return 3;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                checks++; errors++;
                $display("FAIL watchdog actual=%0d expected=0", cycles);
                report();
            end
        end
    end

    // PHY responder model, sampling at the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            if (any_stb()) begin
                int ph;
                logic [W-1:0] v;
                ph = n_seen;
                v  = cr_din;
                if (ph < 4) begin
                    seen_kind[ph] = {cr_write, cr_cap_data, cr_cap_addr};
                    seen_din[ph]  = v;
                end
                n_seen++;
                if (ph == stall_rise_ph) begin
                    hi_cnt = 0;
                    while (any_stb()) begin hi_cnt++; @(negedge clk); end
                end else begin
                    for (int i = 0; i < rise_d; i++) begin
                        @(negedge clk);
                        if (!any_stb() || cr_din != v) stb_ok = 0;
                    end
                    cr_ack = 1'b1;
                    for (int i = 0; i < 3; i++) begin
                        @(negedge clk);
                        if ((i < 2) != any_stb()) lat_ok = 0;
                    end
                    if (cr_din != v) hold_ok = 0;
                    if (ph == stall_fall_ph) begin
                        lo_cnt = 0;
                        while (!err_pulse) begin
                            lo_cnt++;
                            if (any_stb()) order_ok = 0;
                            @(negedge clk);
                        end
                    end else begin
                        for (int i = 0; i < fall_d; i++) begin
                            @(negedge clk);
                            if (any_stb()) order_ok = 0;
                        end
                    end
                    cr_ack = 1'b0;
                    for (int i = 0; i < 2; i++) begin
                        @(negedge clk);
                        if (any_stb()) order_ok = 0;
                    end
                end
            end
        end
    end

    // One write with optional stall and optional busy-time request noise.
    task automatic run_txn(logic [W-1:0] a, logic [W-1:0] d, int sr, int sf, bit noise);
        int  wait_n;
        bit  got_done, got_err;
        logic [1:0] code;
        stall_rise_ph = sr; stall_fall_ph = sf;
        n_seen = 0; hold_ok = 1; lat_ok = 1; order_ok = 1; stb_ok = 1;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_data = d;
        @(negedge clk);
        if (noise) begin
            req_addr = ~a; req_data = ~d;
            for (int i = 0; i < 4; i++) begin
                // R2: busy-time requests are not accepted
                check(!req_ready, "R2 ready while busy", req_ready, 0);
                @(negedge clk);
            end
        end
        req_valid = 1'b0;
        wait_n = 0; got_done = 0; got_err = 0; code = 0;
        while (!done_pulse && !err_pulse && wait_n < 8000) begin
            @(negedge clk); wait_n++;
        end
        got_done = done_pulse; got_err = err_pulse; code = err_code;
        // R7 R8 R9: result kind and cause code
        check(got_done == (exp_code(sr, sf) == 0), "R7 done", got_done, exp_code(sr, sf) == 0);
        check(got_err == (exp_code(sr, sf) != 0), "R8/R9 err", got_err, exp_code(sr, sf) != 0);
        check(int'(code) == exp_code(sr, sf), "R8 R9 err_code", code, exp_code(sr, sf));
        @(negedge clk);
        // R7 R12: one-cycle pulses, back to idle with strobes low (R1 R8)
        check(!done_pulse && !err_pulse && err_code == 0, "R12 pulse width",
              {done_pulse, err_pulse}, 0);
        check(req_ready && !any_stb(), "R1 idle after write", {req_ready, any_stb()}, 2);
        repeat (6) @(negedge clk);
        // R3 R4: phases, strobe order and bus contents
        check(n_seen == exp_phases(sr, sf), "R3 phase count", n_seen, exp_phases(sr, sf));
        for (int p = 0; p < exp_phases(sr, sf) && p < 3; p++) begin
            check(seen_kind[p] == 3'(1 << p), "R3 strobe order", seen_kind[p], 1 << p);
            check(seen_din[p] == ((p == 0) ? a : d), "R4 din value", seen_din[p],
                  (p == 0) ? a : d);
        end
        check(stb_ok && hold_ok, "R5 strobe held and din kept", {stb_ok, hold_ok}, 3);
        check(order_ok, "R6 no strobe before ack low", order_ok, 1);
        check(lat_ok, "R11 ack-to-strobe-fall latency", lat_ok, 1);
        if (sr >= 0) check(hi_cnt == BOUND, "R10 rise wait length", hi_cnt, BOUND);
        if (sf >= 0) check(lo_cnt == BOUND, "R10 fall wait length", lo_cnt, BOUND);
    endtask

    initial begin
        void'($urandom(32'hC0DE_5EED));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(req_ready && !any_stb() && !done_pulse && !err_pulse && cr_din == 0,
              "R1 reset state", {req_ready, any_stb(), done_pulse, err_pulse}, 8);

        // Directed: fixed delays, one with busy-time noise.
        rise_d = 0; fall_d = 0;
        run_txn(16'h0015, 16'h2A09, -1, -1, 1'b0);
        rise_d = 5; fall_d = 4;
        run_txn(16'h1010, 16'h0080, -1, -1, 1'b1);
        // R10: an acknowledge late but inside the bound still completes
        rise_d = BOUND - 40; fall_d = BOUND - 40;
        run_txn(16'hBEEF, 16'h1234, -1, -1, 1'b0);

        // Directed timeouts in every phase.
        rise_d = 2; fall_d = 2;
        for (int p = 0; p < 3; p++) run_txn(16'hA000 + 16'(p), 16'h5000 + 16'(p), p, -1, 1'b0);
        for (int p = 0; p < 3; p++) run_txn(16'hC000 + 16'(p), 16'h6000 + 16'(p), -1, p, 1'b0);

        // Random writes.
        for (int n = 0; n < 30; n++) begin
            rise_d = $urandom_range(0, 12);
            fall_d = $urandom_range(0, 12);
            run_txn(16'($urandom), 16'($urandom), -1, -1, 1'($urandom_range(0, 1)));
        end
        report();
    end
endmodule